// File: doc/BRIEF.md
# Multi-Channel Conversion-Ready Pin Generator

This block watches the conversion-complete strobes of several ADC channels, keeps one new-data flag per channel and drives a single active-low ready pin that tells a host when to fetch results. A two-bit source field picks how the channel events combine:

- wait for the slowest enabled channel;
- react to any enabled channel;
- react only to the first enabled channel of a round.

Channels whose enable bit is clear take no part in the decision.

The pin has two formats. In held-level mode it stays low while the chosen condition is true. In pulse mode it gives one low pulse of a fixed number of clock cycles. When the pin is not asserted it is either driven high or released, with the output-enable low, so that several devices can share one wire. A read-acknowledge from the host clears every pending flag.

Top module: `cvt_ready_pin`

## Requirements
- R1: After reset all new-data flags read 0 and the pin is deasserted (`rdy_pin_n` = 1).
- R2: A strobe on an enabled channel sets that channel's `new_data` bit after the next clock edge. The bit stays set until a read-acknowledge.
- R3: A strobe on a channel whose enable bit is 0 is ignored and leaves that channel's flag at 0.
- R4: A read-acknowledge clears every flag on the next edge. A strobe on an enabled channel in the same cycle wins, and that channel's flag is set.
- R5: Source field 00 (lagging) gives an asserted condition only while every enabled channel has its flag set.
- R6: Source field 01 (any) gives an asserted condition while at least one enabled channel has its flag set. In pulse mode every accepted strobe starts a new pulse.
- R7: Source fields 10 and 11 (leading) give an asserted condition while at least one enabled channel has its flag set. In pulse mode only the transition from no pending data to pending data starts a pulse.
- R8: When the pin is not asserted, `rdy_oe` is 1 if `idle_hiz` = 0 and 0 if `idle_hiz` = 1, and `rdy_pin_n` reads 1. When the pin is asserted, `rdy_oe` is 1.
- R9: With `fmt_pulse` = 0 the pin is low in exactly the cycles where the condition holds. After a read-acknowledge it returns high on the next edge.
- R10: With `fmt_pulse` = 1, a trigger drives the pin low for exactly `PULSE_LEN` cycles (default 4), starting after the triggering edge. A new trigger restarts the count.
- R11: With no channel enabled, the condition is never true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_strobe | input | NUM_CH | One-cycle conversion-complete strobe per channel |
| ch_enable | input | NUM_CH | Channel participates in the decision when 1 |
| src_sel | input | 2 | Source policy: 00 lagging, 01 any, 10/11 leading |
| idle_hiz | input | 1 | 1 releases the pin when it is not asserted |
| fmt_pulse | input | 1 | 0 held level, 1 fixed-length pulse |
| rd_ack | input | 1 | Clears all pending flags |
| rdy_pin_n | output | 1 | Active-low ready pin value |
| rdy_oe | output | 1 | Pin output-enable |
| new_data | output | NUM_CH | Per-channel new-data flags |

## Verification
On every cycle, the assertions check how flags are set and cleared, including an acknowledge colliding with a strobe. They also check the link between the output-enable and the idle selection, the held-level pin against the flags under the any policy, the silent pin with no channel enabled, and an upper bound on pulse length. Some behaviour only the bench scenarios can show: the lagging policy waiting for the last channel, the leading policy refusing to retrigger while data are pending, the exact pulse length, and retriggering under the any policy. The bench shows these with a cycle-accurate model driven by directed and random stimulus.

// File: rtl/cvt_ready_pkg.sv
// Shared types for the conversion-ready pin generator.
package cvt_ready_pkg;

    // Source policy selected by the two-bit source field.
    typedef enum logic [1:0] {
        SRC_LAGGING     = 2'b00,
        SRC_ANY         = 2'b01,
        SRC_LEADING     = 2'b10,
        SRC_LEADING_ALT = 2'b11
    } src_mode_e;

endpackage

// File: rtl/cvt_ready_flag_bank.sv
// Per-channel new-data flags.
// A strobe on an enabled channel sets its flag. A read-acknowledge clears
// all flags, and a same-cycle strobe wins over the acknowledge.
// Assumes strobes are single-cycle and synchronous to clk.
module cvt_ready_flag_bank #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] strobe,
    input  logic [NUM_CH-1:0] enable,
    input  logic              ack,
    output logic [NUM_CH-1:0] accept,
    output logic [NUM_CH-1:0] flags_d,
    output logic [NUM_CH-1:0] flags_q
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            // Strobe acceptance for one channel.
            always_comb begin
                accept[gi] = strobe[gi] & enable[gi];
            end

            // Next flag value: set wins over clear.
            always_comb begin
                if (accept[gi])
                    flags_d[gi] = 1'b1;
                else if (ack)
                    flags_d[gi] = 1'b0;
                else
                    flags_d[gi] = flags_q[gi];
            end

            // Flag storage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags_q[gi] <= 1'b0;
                else
                    flags_q[gi] <= flags_d[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/cvt_ready_source_policy.sv
// Combines channel flags into a ready condition and a pulse trigger.
// Lagging needs all enabled flags set; any/leading need one enabled flag.
// The any policy triggers on every accepted strobe. Lagging and leading
// trigger only when the condition rises.
// Assumes flags_d is the value flags_q takes at the next edge.
module cvt_ready_source_policy #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] flags_q,
    input  logic [NUM_CH-1:0] flags_d,
    input  logic [NUM_CH-1:0] enable,
    input  logic [NUM_CH-1:0] accept,
    input  logic [1:0]        src_sel,
    output logic              cond_now,
    output logic              trigger
);
    import cvt_ready_pkg::*;

    src_mode_e mode;
    logic      cond_next;
    logic      cond_q;

    // Evaluates the selected policy on a flag vector.
    function automatic logic eval_cond(input logic [NUM_CH-1:0] f,
                                       input logic [NUM_CH-1:0] en,
                                       input src_mode_e m);
        logic any_en;
        logic all_set;
        logic any_set;
        any_en  = |en;
        all_set = any_en && ((f & en) == en);
        any_set = |(f & en);
        if (m == SRC_LAGGING)
            return all_set;
        return any_set;
    endfunction

    // Decode of the source field.
    always_comb begin
        mode = src_mode_e'(src_sel);
    end

    // Condition on current and next flag state.
    always_comb begin
        cond_now  = eval_cond(flags_q, enable, mode);
        cond_next = eval_cond(flags_d, enable, mode);
    end

    // Condition history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cond_q <= 1'b0;
        else
            cond_q <= cond_next;
    end

    // Pulse trigger per policy.
    always_comb begin
        case (mode)
            SRC_ANY: trigger = |accept;
            default: trigger = cond_next & ~cond_q;
        endcase
    end

endmodule

// File: rtl/cvt_ready_pulse_shaper.sv
// Output stage: a held level or a fixed-length pulse, plus the idle drive
// selection. Assumes PULSE_LEN >= 1.
module cvt_ready_pulse_shaper #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic cond_now,
    input  logic fmt_pulse,
    input  logic idle_hiz,
    output logic pin_n,
    output logic oe
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             asserted;

    // Pulse-length counter, restarted by each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (trigger)
            cnt_q <= CNT_W'(PULSE_LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Format selection.
    always_comb begin
        asserted = fmt_pulse ? (cnt_q != '0) : cond_now;
    end

    // Pin drive and release.
    always_comb begin
        pin_n = ~asserted;
        oe    = asserted | ~idle_hiz;
    end

endmodule

// File: rtl/cvt_ready_pin.sv
// Top of the conversion-ready pin generator. It wires the flag bank, the
// source policy and the output shaper. All inputs are synchronous to clk.
module cvt_ready_pin #(
    parameter int NUM_CH    = 2,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] conv_strobe,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [1:0]        src_sel,
    input  logic              idle_hiz,
    input  logic              fmt_pulse,
    input  logic              rd_ack,
    output logic              rdy_pin_n,
    output logic              rdy_oe,
    output logic [NUM_CH-1:0] new_data
);

    logic [NUM_CH-1:0] accept;
    logic [NUM_CH-1:0] flags_d;
    logic [NUM_CH-1:0] flags_q;
    logic              cond_now;
    logic              trigger;

    cvt_ready_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (conv_strobe),
        .enable  (ch_enable),
        .ack     (rd_ack),
        .accept  (accept),
        .flags_d (flags_d),
        .flags_q (flags_q)
    );

    cvt_ready_source_policy #(.NUM_CH(NUM_CH)) u_policy (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_q  (flags_q),
        .flags_d  (flags_d),
        .enable   (ch_enable),
        .accept   (accept),
        .src_sel  (src_sel),
        .cond_now (cond_now),
        .trigger  (trigger)
    );

    cvt_ready_pulse_shaper #(.PULSE_LEN(PULSE_LEN)) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger   (trigger),
        .cond_now  (cond_now),
        .fmt_pulse (fmt_pulse),
        .idle_hiz  (idle_hiz),
        .pin_n     (rdy_pin_n),
        .oe        (rdy_oe)
    );

    // Flags are visible directly.
    always_comb begin
        new_data = flags_q;
    end

endmodule

// File: rtl/cvt_ready_pin_chk.sv
// Port-level checker for cvt_ready_pin, bound into every instance.
module cvt_ready_pin_chk #(
    parameter int NUM_CH    = 2,
    parameter int PULSE_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] conv_strobe,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [1:0]        src_sel,
    input logic              idle_hiz,
    input logic              fmt_pulse,
    input logic              rd_ack,
    input logic              rdy_pin_n,
    input logic              rdy_oe,
    input logic [NUM_CH-1:0] new_data
);
    localparam int RUN_W = $clog2(PULSE_LEN + 2);

    logic [RUN_W-1:0]  low_run;
    logic [NUM_CH-1:0] en_prev;
    logic [1:0]        sel_prev;
    logic              restart;

    // Any event that may legitimately start or restart a pulse.
    always_comb begin
        restart = (|(conv_strobe & ch_enable)) || (ch_enable != en_prev) ||
                  (src_sel != sel_prev) || !fmt_pulse;
    end

    // Consecutive low cycles since the last possible trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= '0;
            en_prev  <= '0;
            sel_prev <= '0;
        end else begin
            en_prev  <= ch_enable;
            sel_prev <= src_sel;
            if (restart || rdy_pin_n)
                low_run <= '0;
            else if (low_run <= RUN_W'(PULSE_LEN))
                low_run <= low_run + 1'b1;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            // R2
            flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (conv_strobe[gi] && ch_enable[gi]) |=> new_data[gi]);
            // R3
            disabled_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_enable[gi] && !new_data[gi]) |=> !new_data[gi]);
            // R4
            ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_ack && !(conv_strobe[gi] && ch_enable[gi])) |=> !new_data[gi]);
        end
    endgenerate

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_oe |-> (idle_hiz && rdy_pin_n));
    // R8
    idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_hiz |-> rdy_oe);
    // R6
    any_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_pulse && src_sel == 2'b01) |-> (rdy_pin_n == !(|(new_data & ch_enable))));
    // R11
    none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_pulse && ch_enable == '0) |-> rdy_pin_n);
    // R10
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_pulse && !rdy_pin_n) |-> (low_run < RUN_W'(PULSE_LEN)));

endmodule

bind cvt_ready_pin cvt_ready_pin_chk #(.NUM_CH(NUM_CH), .PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/cvt_ready_pin_tb.sv
`timescale 1ns/1ps
module cvt_ready_pin_tb;
    localparam int NCH = 2;
    localparam int PL  = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] conv_strobe;
    logic [NCH-1:0] ch_enable;
    logic [1:0]     src_sel;
    logic           idle_hiz;
    logic           fmt_pulse;
    logic           rd_ack;
    logic           rdy_pin_n;
    logic           rdy_oe;
    logic [NCH-1:0] new_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state
    logic [NCH-1:0] m_flags;
    logic           m_cond_q;
    int             m_cnt;
    logic           m_prev_ack;

    always #2.5 clk = ~clk;

    cvt_ready_pin #(.NUM_CH(NCH), .PULSE_LEN(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .ch_enable(ch_enable),
        .src_sel(src_sel), .idle_hiz(idle_hiz), .fmt_pulse(fmt_pulse), .rd_ack(rd_ack),
        .rdy_pin_n(rdy_pin_n), .rdy_oe(rdy_oe), .new_data(new_data)
    );

    function automatic logic cond_f(input logic [NCH-1:0] f, input logic [NCH-1:0] en,
                                    input logic [1:0] s);
        if (s == 2'b00) return (en != 0) && ((f & en) == en);
        return (f & en) != 0;
    endfunction

    function automatic logic exp_asserted();
        if (fmt_pulse) return m_cnt != 0;
        return cond_f(m_flags, ch_enable, src_sel);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference update at each active edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0; m_cond_q = 1'b0; m_cnt = 0; m_prev_ack = 1'b0;
        end else begin
            logic [NCH-1:0] acc;
            logic [NCH-1:0] nf;
            logic           trig;
            logic           cn;
            acc  = conv_strobe & ch_enable;
            nf   = (m_flags & ~{NCH{rd_ack}}) | acc;
            cn   = cond_f(nf, ch_enable, src_sel);
            trig = (src_sel == 2'b01) ? (acc != 0) : (cn && !m_cond_q);
            if (trig) m_cnt = PL; else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_cond_q   = cn;
            m_flags    = nf;
            m_prev_ack = rd_ack;
        end
    end

    // Applies one cycle of inputs and compares all outputs mid-cycle.
    task automatic cyc(input logic [NCH-1:0] stb, input logic ack);
        string ftag;
        string ptag;
        logic  a;
        conv_strobe = stb; rd_ack = ack;
        ftag = ack ? "R4" : (((stb & ~ch_enable) != 0) ? "R3" : "R2");
        @(posedge clk);
        @(negedge clk);
        a = exp_asserted();
        if (fmt_pulse)             ptag = "R10";
        else if (ch_enable == 0)   ptag = "R11";
        else if (m_prev_ack)       ptag = "R9";
        else if (src_sel == 2'b00) ptag = "R5";
        else if (src_sel == 2'b01) ptag = "R6";
        else                       ptag = "R7";
        check(ftag, new_data, m_flags);
        check(ptag, rdy_pin_n, !a);
        check("R8", rdy_oe, a || !idle_hiz);
        conv_strobe = '0; rd_ack = 1'b0;
    endtask

    task automatic cfg(input logic [NCH-1:0] en, input logic [1:0] s,
                       input logic hz, input logic fp);
        ch_enable = en; src_sel = s; idle_hiz = hz; fmt_pulse = fp;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; conv_strobe = '0; rd_ack = 1'b0;
        cfg(2'b11, 2'b00, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", new_data, 0);
        check("R1", rdy_pin_n, 1);
        check("R1", rdy_oe, 1);

        // R5 lagging waits for both channels
        cyc(2'b01, 1'b0);
        cyc(2'b10, 1'b0);
        check("R5", rdy_pin_n, 0);
        cyc(2'b00, 1'b1);                 // R9 release after ack
        check("R9", rdy_pin_n, 1);
        // R6 any channel, R4 collision
        cfg(2'b11, 2'b01, 1'b0, 1'b0);
        cyc(2'b10, 1'b0);
        cyc(2'b01, 1'b1);
        check("R4", new_data, 2'b01);
        cyc(2'b00, 1'b1);
        // R3 disabled channel ignored
        cfg(2'b01, 2'b01, 1'b1, 1'b0);
        cyc(2'b10, 1'b0);
        check("R3", new_data, 0);
        check("R8", rdy_oe, 0);
        // R11 nothing enabled
        cfg(2'b00, 2'b10, 1'b0, 1'b0);
        cyc(2'b11, 1'b0);
        check("R11", rdy_pin_n, 1);
        // R10 pulse under leading, then R7 no retrigger
        cfg(2'b11, 2'b10, 1'b1, 1'b1);
        cyc(2'b01, 1'b0);
        for (int i = 0; i < 6; i++) cyc(2'b00, 1'b0);
        cyc(2'b10, 1'b0);
        check("R7", rdy_pin_n, 1);
        cyc(2'b00, 1'b1);
        // R6 any policy retriggers on each strobe
        cfg(2'b11, 2'b01, 1'b0, 1'b1);
        cyc(2'b01, 1'b0);
        cyc(2'b00, 1'b0);
        cyc(2'b10, 1'b0);
        for (int i = 0; i < 6; i++) cyc(2'b00, 1'b0);
        cyc(2'b00, 1'b1);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0)
                cfg(NCH'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            cyc(NCH'(($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 0),
                1'($urandom_range(0, 7) == 0));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule